// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers interrupt requests from eight input lines, decides which one the processor should serve next, and tracks which lines are being served. A rising edge on a request line sets a pending bit. Pending bits whose mask bit is clear take part in arbitration. The winner may also not be blocked by a line that is already in service. When a winner exists the interrupt output is high. A one-cycle acknowledge strobe then returns an 8-bit vector, moves the winner from pending to in-service, and releases the request.

Priority is a circular order. A three-bit pointer names the lowest-priority line, and the line just after it is the highest. After reset the pointer is 7, so line 0 is highest. Software controls the block through a small write port with three targets: the mask, the operation word and the mode word. The operation word ends service and moves the priority pointer. The mode word turns on special mask mode and automatic end of service. A read port returns the pending, in-service and mask registers and a status byte.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending, in-service and mask registers all read 0x00 and the status byte reads 0x07. Status bit 7 is special mask mode, bit 6 is automatic end of service, bit 5 is rotate-on-auto-end, and bits 2..0 are the lowest-priority line. `int_out` is low after reset.
- R2: A low-to-high transition on `irq_in[n]` sets pending bit n at the next clock edge. The bit stays set until that line is acknowledged. A line held high after its acknowledge does not request again.
- R3: A set mask bit n keeps line n out of arbitration and keeps `int_out` from rising for it. Pending bit n is still recorded. Clearing the mask bit releases the request.
- R4: Line ranks start at 0 for the line after the lowest-priority pointer and grow in circular order. An acknowledge picks the pending unmasked line of lowest rank and returns `{VEC_BASE[7:3], n}`. At the clock edge it sets in-service bit n and clears pending bit n.
- R5: Outside special mask mode, a request wins only if its rank is strictly below the lowest rank among in-service bits. An in-service line therefore also blocks a new request on the same line.
- R6: An operation write (address 1) with bits 7..5 = 001 clears the in-service bit of lowest rank.
- R7: Operation code 011 clears the in-service bit named by bits 2..0.
- R8: Code 101 clears the in-service bit of lowest rank and makes that line the lowest priority. Code 111 clears the in-service bit named by bits 2..0 and makes that line the lowest priority.
- R9: Code 110 makes the line in bits 2..0 the lowest priority without touching in-service bits.
- R10: Code 000 changes neither the in-service bits nor the status byte.
- R11: A mode write (address 2) with bits 6..5 = 11 enters special mask mode, and 10 leaves it. In this mode an in-service bit whose mask bit is set no longer blocks other lines.
- R12: A mode write with bit 1 set loads automatic end of service from bit 0. While this is on, an acknowledge leaves no in-service bit. Operation code 100 turns on rotate-on-auto-end and code 010 turns it off. With both on, the acknowledged line becomes the lowest priority.
- R13: An acknowledge while `int_out` is low returns `{VEC_BASE[7:3], 3'd7}` and changes no register.
- R14: `rd_data` shows, by `rd_addr`, the pending register (0), the in-service register (1), the mask (2) or the status byte (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Edge-triggered request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mask, 1 operation word, 2 mode word, 3 ignored |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read select |
| rd_data | output | 8 | Read data |
| ack | input | 1 | Acknowledge strobe, one cycle |
| int_out | output | 1 | A request is ready to be served |
| vec_out | output | 8 | Vector, valid while ack is high |

## Verification
A wrong in-service bit shows itself within one acknowledge. A stale bit holds `int_out` low for a lower-ranked request that should pass. A missing bit lets a same-line or lower request raise `int_out` in the very next cycle. A wrong priority pointer shows in the vector returned at the next acknowledge where two lines compete, and at once in status bits 2..0. For each of these faults the bench sets up two or three lines and reads the vectors and register contents one cycle after each command.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LINES = 8;
    localparam int LVL_W = $clog2(LINES);

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [LINES-1:0] line_vec_t;

    typedef enum logic [2:0] {
        OP_NOP       = 3'b000,
        OP_NS_EOI    = 3'b001,
        OP_AROT_OFF  = 3'b010,
        OP_SP_EOI    = 3'b011,
        OP_AROT_ON   = 3'b100,
        OP_ROT_NS    = 3'b101,
        OP_SET_LOW   = 3'b110,
        OP_ROT_SP    = 3'b111
    } op_code_e;

    typedef enum logic [1:0] {
        WA_MASK = 2'd0,
        WA_OP   = 2'd1,
        WA_MODE = 2'd2,
        WA_NONE = 2'd3
    } wr_addr_e;

    typedef struct packed {
        logic hit;
        lvl_t lvl;
    } pick_t;

    typedef struct packed {
        logic smm;
        logic aeoi;
        logic rot_aeoi;
    } mode_t;

    // rank 0 is the line just after the lowest-priority pointer
    function automatic lvl_t rank_of(lvl_t line, lvl_t lowest);
        return line - lowest - lvl_t'(1);
    endfunction

    // first set bit in circular priority order
    function automatic pick_t pick_first(line_vec_t v, lvl_t lowest);
        pick_t p;
        p = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            lvl_t ln;
            ln = lowest + lvl_t'(k) + lvl_t'(1);
            if (v[ln]) begin
                p.hit = 1'b1;
                p.lvl = ln;
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch
    import pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t irq_in,
    input  logic      clr_en,
    input  lvl_t      clr_lvl,
    output line_vec_t irr
);
    line_vec_t prev_q;
    line_vec_t rise;
    line_vec_t clr_mask;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign rise[g]     = irq_in[g] & ~prev_q[g];
        assign clr_mask[g] = clr_en && (clr_lvl == lvl_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            irr    <= '0;
        end else begin
            prev_q <= irq_in;
            irr    <= (irr & ~clr_mask) | rise;
        end
    end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
(
    input  line_vec_t irr,
    input  line_vec_t imr,
    input  line_vec_t isr,
    input  logic      smm,
    input  lvl_t      low_lvl,
    output logic      grant,
    output lvl_t      win_lvl
);
    line_vec_t cand;
    line_vec_t blockers;
    pick_t     top_req;
    pick_t     top_blk;
    lvl_t      req_rank;
    lvl_t      blk_rank;

    always_comb begin
        cand     = irr & ~imr;
        blockers = smm ? (isr & ~imr) : isr;
        top_req  = pick_first(cand, low_lvl);
        top_blk  = pick_first(blockers, low_lvl);
        req_rank = rank_of(top_req.lvl, low_lvl);
        blk_rank = rank_of(top_blk.lvl, low_lvl);
        grant    = top_req.hit && (!top_blk.hit || (req_rank < blk_rank));
        win_lvl  = top_req.lvl;
    end
endmodule

// File: rtl/pic_service.sv
module pic_service
    import pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ack_grant,
    input  lvl_t      win_lvl,
    input  logic      op_we,
    input  op_code_e  op_code,
    input  lvl_t      op_lvl,
    input  logic      mode_we,
    input  logic [1:0] mode_smm_bits,
    input  logic [1:0] mode_aeoi_bits,
    output line_vec_t isr,
    output lvl_t      low_lvl,
    output mode_t     mode
);
    line_vec_t isr_n;
    lvl_t      low_n;
    mode_t     mode_n;
    pick_t     top_isr;

    always_comb begin
        isr_n   = isr;
        low_n   = low_lvl;
        mode_n  = mode;
        top_isr = pick_first(isr, low_lvl);

        if (ack_grant) begin
            if (!mode.aeoi) isr_n[win_lvl] = 1'b1;
            else if (mode.rot_aeoi) low_n = win_lvl;
        end

        if (op_we) begin
            case (op_code)
                OP_NS_EOI: if (top_isr.hit) isr_n[top_isr.lvl] = 1'b0;
                OP_SP_EOI: isr_n[op_lvl] = 1'b0;
                OP_ROT_NS: if (top_isr.hit) begin
                    isr_n[top_isr.lvl] = 1'b0;
                    low_n = top_isr.lvl;
                end
                OP_ROT_SP: begin
                    isr_n[op_lvl] = 1'b0;
                    low_n = op_lvl;
                end
                OP_SET_LOW:  low_n = op_lvl;
                OP_AROT_ON:  mode_n.rot_aeoi = 1'b1;
                OP_AROT_OFF: mode_n.rot_aeoi = 1'b0;
                default: ;
            endcase
        end

        if (mode_we) begin
            if (mode_smm_bits == 2'b11) mode_n.smm = 1'b1;
            else if (mode_smm_bits == 2'b10) mode_n.smm = 1'b0;
            if (mode_aeoi_bits[1]) mode_n.aeoi = mode_aeoi_bits[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr     <= '0;
            low_lvl <= lvl_t'(LINES - 1);
            mode    <= '0;
        end else begin
            isr     <= isr_n;
            low_lvl <= low_n;
            mode    <= mode_n;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter logic [7:0] VEC_BASE = 8'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] irq_in,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       ack,
    output logic       int_out,
    output logic [7:0] vec_out
);
    localparam lvl_t SPUR_LVL = lvl_t'(LINES - 1);

    line_vec_t irr_q;
    line_vec_t isr_q;
    line_vec_t imr_q;
    lvl_t      low_lvl;
    mode_t     mode;
    logic      grant;
    lvl_t      win_lvl;
    logic      ack_grant;
    logic      smm_on;
    logic      aeoi_on;
    wr_addr_e  waddr;

    assign waddr     = wr_addr_e'(wr_addr);
    assign ack_grant = ack && grant;
    assign smm_on    = mode.smm;
    assign aeoi_on   = mode.aeoi;

    always_ff @(posedge clk) begin
        if (rst) imr_q <= '0;
        else if (wr_en && waddr == WA_MASK) imr_q <= wr_data;
    end

    pic_req_latch u_req (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .clr_en  (ack_grant),
        .clr_lvl (win_lvl),
        .irr     (irr_q)
    );

    pic_resolver u_res (
        .irr     (irr_q),
        .imr     (imr_q),
        .isr     (isr_q),
        .smm     (mode.smm),
        .low_lvl (low_lvl),
        .grant   (grant),
        .win_lvl (win_lvl)
    );

    pic_service u_svc (
        .clk            (clk),
        .rst            (rst),
        .ack_grant      (ack_grant),
        .win_lvl        (win_lvl),
        .op_we          (wr_en && waddr == WA_OP),
        .op_code        (op_code_e'(wr_data[7:5])),
        .op_lvl         (wr_data[2:0]),
        .mode_we        (wr_en && waddr == WA_MODE),
        .mode_smm_bits  (wr_data[6:5]),
        .mode_aeoi_bits (wr_data[1:0]),
        .isr            (isr_q),
        .low_lvl        (low_lvl),
        .mode           (mode)
    );

    always_comb begin
        case (rd_addr)
            2'd0:    rd_data = irr_q;
            2'd1:    rd_data = isr_q;
            2'd2:    rd_data = imr_q;
            default: rd_data = {mode.smm, mode.aeoi, mode.rot_aeoi, 2'b00, low_lvl};
        endcase
    end

    assign int_out = grant;
    assign vec_out = {VEC_BASE[7:3], grant ? win_lvl : SPUR_LVL};
endmodule

// File: rtl/pic_checks.sv
module pic_checks
    import pic_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ack,
    input logic       int_out,
    input logic [7:0] vec_out,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [2:0] op_bits,
    input line_vec_t  irr,
    input line_vec_t  isr,
    input line_vec_t  imr,
    input logic       smm,
    input logic       aeoi,
    input lvl_t       low
);
    logic op_wr;
    assign op_wr = wr_en && (wr_addr == 2'd1);

    // int_out needs an unmasked pending request
    assert_int_unmasked_R3: assert property (@(posedge clk) disable iff (rst)
        int_out |-> |(irr & ~imr));

    // granted line lands in service
    assert_ack_sets_isr_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && !aeoi && !wr_en) |=> isr[$past(vec_out[2:0])]);

    // no grant of a line already in service outside special mask mode
    assert_nested_block_R5: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && !smm) |-> !isr[vec_out[2:0]]);

    // non-specific end clears exactly one bit
    assert_ns_eoi_R6: assert property (@(posedge clk) disable iff (rst)
        (op_wr && op_bits == 3'b001 && |isr && !ack)
        |=> $countones(isr) == $countones($past(isr)) - 1);

    // no-op code leaves service and priority alone
    assert_nop_R10: assert property (@(posedge clk) disable iff (rst)
        (op_wr && op_bits == 3'b000 && !ack) |=> ($stable(isr) && $stable(low)));

    // spurious acknowledge changes nothing in service
    assert_spurious_R13: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_out && !wr_en) |=> $stable(isr));
endmodule

bind prio_irq_ctrl pic_checks u_chk (
    .clk     (clk),
    .rst     (rst),
    .ack     (ack),
    .int_out (int_out),
    .vec_out (vec_out),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .op_bits (wr_data[7:5]),
    .irr     (irr_q),
    .isr     (isr_q),
    .imr     (imr_q),
    .smm     (smm_on),
    .aeoi    (aeoi_on),
    .low     (low_lvl)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ack = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ack(ack),
        .int_out(int_out), .vec_out(vec_out)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            finish_run();
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic chk_reg(string tag, logic [1:0] a, logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic chk_int(string tag, logic exp);
        #1;
        chk(tag, {7'd0, int_out}, {7'd0, exp});
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse(logic [7:0] lines);
        irq_in = irq_in | lines;
        step();
        irq_in = irq_in & ~lines;
        step();
    endtask

    task automatic do_ack(string tag, logic [7:0] exp_vec);
        ack = 1'b1;
        #1;
        chk(tag, vec_out, exp_vec);
        step();
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk_reg("R1 pending", 2'd0, 8'h00);
        chk_reg("R1 in-service", 2'd1, 8'h00);
        chk_reg("R1 mask", 2'd2, 8'h00);
        chk_reg("R1 status", 2'd3, 8'h07);
        chk_int("R1 int_out", 1'b0);
    endtask

    task automatic t_edge();
        irq_in[3] = 1'b1;
        step();
        chk_reg("R2 pending set", 2'd0, 8'h08);
        chk_int("R2 int high", 1'b1);
        do_ack("R2 vector", 8'h23);
        step(); step();
        chk_reg("R2 held level no re-request", 2'd0, 8'h00);
        chk_reg("R4 in-service", 2'd1, 8'h08);
        irq_in[3] = 1'b0;
        wr(2'd1, 8'h20);
        chk_reg("R6 cleared", 2'd1, 8'h00);
    endtask

    task automatic t_mask();
        wr(2'd0, 8'h04);
        pulse(8'h04);
        chk_reg("R3 recorded", 2'd0, 8'h04);
        chk_int("R3 masked int", 1'b0);
        wr(2'd0, 8'h00);
        chk_int("R3 unmasked int", 1'b1);
        do_ack("R3 vector", 8'h22);
        wr(2'd1, 8'h20);
    endtask

    task automatic t_nested();
        pulse(8'h22);
        do_ack("R4 highest wins", 8'h21);
        chk_reg("R4 isr", 2'd1, 8'h02);
        chk_reg("R4 irr keeps loser", 2'd0, 8'h20);
        chk_int("R5 lower blocked", 1'b0);
        pulse(8'h01);
        chk_int("R5 higher passes", 1'b1);
        do_ack("R5 nested vector", 8'h20);
        chk_reg("R5 two in service", 2'd1, 8'h03);
        wr(2'd1, 8'h20);
        chk_reg("R6 clears top", 2'd1, 8'h02);
        chk_int("R5 still blocked", 1'b0);
        wr(2'd1, 8'h61);
        chk_reg("R7 specific", 2'd1, 8'h00);
        do_ack("R4 loser served", 8'h25);
        pulse(8'h20);
        chk_reg("R5 same line pending", 2'd0, 8'h20);
        chk_int("R5 same line blocked", 1'b0);
        wr(2'd1, 8'h20);
        chk_int("R5 released", 1'b1);
        do_ack("R5 same line vector", 8'h25);
        wr(2'd1, 8'h20);
    endtask

    task automatic t_rotate();
        pulse(8'h04);
        do_ack("R8 setup", 8'h22);
        wr(2'd1, 8'hA0);
        chk_reg("R8 rot ns isr", 2'd1, 8'h00);
        chk_reg("R8 rot ns low", 2'd3, 8'h02);
        pulse(8'h0A);
        do_ack("R8 rotated order", 8'h23);
        chk_int("R5 rotated block", 1'b0);
        wr(2'd1, 8'h20);
        do_ack("R8 second", 8'h21);
        wr(2'd1, 8'h20);
        wr(2'd1, 8'hC4);
        chk_reg("R9 set low", 2'd3, 8'h04);
        pulse(8'h30);
        do_ack("R9 order", 8'h25);
        wr(2'd1, 8'h20);
        do_ack("R9 lowest last", 8'h24);
        wr(2'd1, 8'h20);
        pulse(8'h40);
        do_ack("R8 specific setup", 8'h26);
        wr(2'd1, 8'hE6);
        chk_reg("R8 rot sp isr", 2'd1, 8'h00);
        chk_reg("R8 rot sp low", 2'd3, 8'h06);
        wr(2'd1, 8'hC7);
        chk_reg("R9 restore", 2'd3, 8'h07);
    endtask

    task automatic t_nop();
        pulse(8'h10);
        do_ack("R10 setup", 8'h24);
        wr(2'd1, 8'h00);
        chk_reg("R10 isr kept", 2'd1, 8'h10);
        chk_reg("R10 status kept", 2'd3, 8'h07);
        wr(2'd1, 8'h20);
    endtask

    task automatic t_smm();
        pulse(8'h04);
        do_ack("R11 setup", 8'h22);
        wr(2'd0, 8'h04);
        pulse(8'h40);
        chk_int("R11 blocked before", 1'b0);
        wr(2'd2, 8'h60);
        chk_reg("R11 status", 2'd3, 8'h87);
        chk_int("R11 passes", 1'b1);
        do_ack("R11 vector", 8'h26);
        chk_reg("R11 isr", 2'd1, 8'h44);
        wr(2'd1, 8'h66);
        wr(2'd1, 8'h62);
        wr(2'd2, 8'h40);
        chk_reg("R11 cleared", 2'd3, 8'h07);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_aeoi();
        wr(2'd2, 8'h03);
        chk_reg("R12 status", 2'd3, 8'h47);
        pulse(8'h08);
        do_ack("R12 vector", 8'h23);
        chk_reg("R12 no isr", 2'd1, 8'h00);
        wr(2'd1, 8'h80);
        chk_reg("R12 rot on", 2'd3, 8'h67);
        pulse(8'h02);
        do_ack("R12 rot vector", 8'h21);
        chk_reg("R12 rotated", 2'd3, 8'h61);
        wr(2'd1, 8'h40);
        chk_reg("R12 rot off", 2'd3, 8'h41);
        wr(2'd1, 8'hC7);
        wr(2'd2, 8'h02);
        chk_reg("R12 off", 2'd3, 8'h07);
    endtask

    task automatic t_spurious();
        chk_int("R13 idle", 1'b0);
        do_ack("R13 vector", 8'h27);
        chk_reg("R13 isr", 2'd1, 8'h00);
        chk_reg("R13 irr", 2'd0, 8'h00);
        chk_reg("R14 status read", 2'd3, 8'h07);
    endtask

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_edge();
        t_mask();
        t_nested();
        t_rotate();
        t_nop();
        t_smm();
        t_aeoi();
        t_spurious();
        finish_run();
    end
endmodule